// File: doc/BRIEF.md
# ISA 16-bit Slave Cycle Responder

This block sits on an expansion card attached to a 16-bit ISA-style bus. It answers memory and I/O cycles that land inside its own address windows. For memory, it looks at the latched upper address bits 23 down to 17 and claims the cycle as a 16-bit transfer. For I/O, it looks at address bits 15 down to 1 and does the same. The two select outputs are combinational from the address, so they settle before any command strobe arrives.

A 16-bit cycle normally gets one wait state from the host. When the local resource needs more time than that, the block pulls the channel-ready line inactive for a programmable number of bus clocks. Each window has its own 4-bit extra-wait count. None of the three bus lines is ever driven high: each is either pulled low or released. Each line is modelled as a data output that is always zero plus an output enable.

Each window has a base and a mask. A window hits when the address, masked, equals the base, masked. When windows overlap, the window with the lowest index supplies the wait count.

Top module: `isa16_slave_resp`

## Requirements
- R1: `memcs_oe_o` is 1 exactly when at least one memory window i satisfies `(la_i & mem_mask[i]) == (mem_base[i] & mem_mask[i])`. Window i takes bits [7i+6:7i] of the flat config buses, and `la_i[6:0]` carries address bits 23..17. The output depends only on address and configuration, never on a strobe or the clock.
- R2: `iocs_oe_o` is 1 exactly when at least one I/O window i satisfies the same masked equality on `sa_i[15:1]`. Window i takes bits [15i+14:15i] of the flat config buses. `sa_i[0]` has no effect.
- R3: `memcs_o`, `iocs_o` and `rdy_o` are 0 at all times, so the lines are only ever pulled low or released.
- R4: A cycle starts at the first rising clock edge where any command strobe (`memr_ni`, `memw_ni`, `ior_ni`, `iow_ni`, all active low) is sampled low after an edge with all of them high. At that start, a memory strobe with a memory hit, or an I/O strobe with an I/O hit, loads W, the extra-wait count of the lowest-index hitting window in that space. Window i's count is at bits [4i+3:4i].
- R5: After a start with W > 0, `rdy_oe_o` is 1 from that edge up to the W-th following edge, which is W clock periods, and is then released. With W = 0 it never rises.
- R6: `rdy_oe_o` is 0 whenever all command strobes are high. If the strobe is released early, the stretch ends, and the next cycle starts a fresh count.
- R7: A cycle whose strobe space has no hitting window never asserts `rdy_oe_o`.
- R8: While `rst_ni` is low and after its release, the wait counter is idle and `rdy_oe_o` is 0 until a cycle starts.
- R9: When several windows of one space hit, the lowest index decides the wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| la_i | input | 7 | Latched memory address bits 23..17 |
| sa_i | input | 16 | System address bits 15..0 |
| memr_ni | input | 1 | Memory read strobe, active low |
| memw_ni | input | 1 | Memory write strobe, active low |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| mem_base_i | input | 14 | Memory window bases, 7 bits each |
| mem_mask_i | input | 14 | Memory window masks, 7 bits each |
| mem_wait_i | input | 8 | Memory window extra waits, 4 bits each |
| io_base_i | input | 30 | I/O window bases, 15 bits each |
| io_mask_i | input | 30 | I/O window masks, 15 bits each |
| io_wait_i | input | 8 | I/O window extra waits, 4 bits each |
| memcs_oe_o | output | 1 | Pull the memory 16-bit select low |
| memcs_o | output | 1 | Memory select data value, always 0 |
| iocs_oe_o | output | 1 | Pull the I/O 16-bit select low |
| iocs_o | output | 1 | I/O select data value, always 0 |
| rdy_oe_o | output | 1 | Pull channel ready low |
| rdy_o | output | 1 | Ready data value, always 0 |

## Verification
The bench goes after these corner cases:

- **Zero and maximum wait counts.** A design that is off by one in its countdown would hold ready low for W-1 or W+1 clocks, or would pulse it once for W = 0.
- **Overlapping windows with different waits.** A design with the priority reversed would use the higher window's count.
- **Strobe released in the middle of a stretch, then reasserted.** A design that kept counting would drive ready with no cycle in progress, or would resume a stale count instead of reloading.
- **Toggling I/O bit 0 and striking a strobe on an unclaimed address.** A design that used bit 0, or that gated the counter without the hit, would claim cycles that belong to other cards.

// File: rtl/isa16_pkg.sv
package isa16_pkg;
  localparam int unsigned MEM_AW = 7;   // address bits 23..17
  localparam int unsigned IO_AW  = 15;  // address bits 15..1
  localparam int unsigned WAIT_W = 4;

  typedef logic [WAIT_W-1:0] wait_t;
endpackage

// File: rtl/isa16_win_dec.sv
module isa16_win_dec #(
  parameter int unsigned N_WIN = 2,
  parameter int unsigned AW    = 7,
  parameter int unsigned WW    = 4
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [N_WIN*AW-1:0] base_i,
  input  logic [N_WIN*AW-1:0] mask_i,
  input  logic [N_WIN*WW-1:0] wait_i,
  output logic                hit_o,
  output logic [WW-1:0]       wait_o
);
  logic [N_WIN-1:0] match;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    logic [AW-1:0] b, m;
    assign b = base_i[g*AW +: AW];
    assign m = mask_i[g*AW +: AW];
    assign match[g] = ((addr_i & m) == (b & m));
  end

  assign hit_o = |match;

  // walk high to low so the lowest index wins
  always_comb begin
    wait_o = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (match[i]) wait_o = wait_i[i*WW +: WW];
    end
  end
endmodule

// File: rtl/isa16_wait_ctr.sv
module isa16_wait_ctr #(
  parameter int unsigned WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_i,
  input  logic          hit_i,
  input  logic [WW-1:0] wait_i,
  output logic          hold_o
);
  logic          cmd_q;
  logic [WW-1:0] cnt_q;
  logic          start;

  assign start  = cmd_i & ~cmd_q & hit_i;
  assign hold_o = cmd_i & (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cmd_q <= cmd_i;
      if (!cmd_i)            cnt_q <= '0;
      else if (start)        cnt_q <= wait_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> cnt_q == $past(wait_i));

  assert_countdown_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && cmd_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && cmd_q && cnt_q == 1) |=> !hold_o);

  assert_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i |=> cnt_q == '0);

  assert_no_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && !cmd_q && !hit_i) |=> cnt_q == '0);
endmodule

// File: rtl/isa16_slave_resp.sv
module isa16_slave_resp
  import isa16_pkg::*;
#(
  parameter int unsigned N_MEM_WIN = 2,
  parameter int unsigned N_IO_WIN  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [MEM_AW-1:0]           la_i,
  input  logic [15:0]                 sa_i,
  input  logic                        memr_ni,
  input  logic                        memw_ni,
  input  logic                        ior_ni,
  input  logic                        iow_ni,
  input  logic [N_MEM_WIN*MEM_AW-1:0] mem_base_i,
  input  logic [N_MEM_WIN*MEM_AW-1:0] mem_mask_i,
  input  logic [N_MEM_WIN*WAIT_W-1:0] mem_wait_i,
  input  logic [N_IO_WIN*IO_AW-1:0]   io_base_i,
  input  logic [N_IO_WIN*IO_AW-1:0]   io_mask_i,
  input  logic [N_IO_WIN*WAIT_W-1:0]  io_wait_i,
  output logic                        memcs_oe_o,
  output logic                        memcs_o,
  output logic                        iocs_oe_o,
  output logic                        iocs_o,
  output logic                        rdy_oe_o,
  output logic                        rdy_o
);
  logic  mem_hit, io_hit;
  wait_t mem_wait, io_wait, sel_wait;
  logic  mem_cmd, io_cmd, any_cmd, go_hit;

  isa16_win_dec #(.N_WIN(N_MEM_WIN), .AW(MEM_AW), .WW(WAIT_W)) i_mem_dec (
    .addr_i (la_i),
    .base_i (mem_base_i),
    .mask_i (mem_mask_i),
    .wait_i (mem_wait_i),
    .hit_o  (mem_hit),
    .wait_o (mem_wait)
  );

  isa16_win_dec #(.N_WIN(N_IO_WIN), .AW(IO_AW), .WW(WAIT_W)) i_io_dec (
    .addr_i (sa_i[15:1]),
    .base_i (io_base_i),
    .mask_i (io_mask_i),
    .wait_i (io_wait_i),
    .hit_o  (io_hit),
    .wait_o (io_wait)
  );

  assign mem_cmd = ~memr_ni | ~memw_ni;
  assign io_cmd  = ~ior_ni  | ~iow_ni;
  assign any_cmd = mem_cmd | io_cmd;

  // memory space takes the cycle if both spaces claim it
  always_comb begin
    go_hit   = 1'b0;
    sel_wait = '0;
    if (mem_cmd && mem_hit) begin
      go_hit   = 1'b1;
      sel_wait = mem_wait;
    end else if (io_cmd && io_hit) begin
      go_hit   = 1'b1;
      sel_wait = io_wait;
    end
  end

  isa16_wait_ctr #(.WW(WAIT_W)) i_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (any_cmd),
    .hit_i  (go_hit),
    .wait_i (sel_wait),
    .hold_o (rdy_oe_o)
  );

  assign memcs_oe_o = mem_hit;
  assign iocs_oe_o  = io_hit;
  assign memcs_o    = 1'b0;
  assign iocs_o     = 1'b0;
  assign rdy_o      = 1'b0;

  assert_rdy_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memr_ni && memw_ni && ior_ni && iow_ni) |-> !rdy_oe_o);

  assert_rdy_after_reset_R8: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !rdy_oe_o);
endmodule

// File: tb/test_isa16_slave_resp.sv
`timescale 1ns/1ps
module test_isa16_slave_resp;
  localparam int NM = 2, NI = 2, MA = 7, IA = 15, WW = 4;

  logic clk = 0, rst_ni = 0;
  logic [MA-1:0] la;
  logic [15:0] sa;
  logic memr_n = 1, memw_n = 1, ior_n = 1, iow_n = 1;
  logic [NM*MA-1:0] mbase, mmask;
  logic [NM*WW-1:0] mwait;
  logic [NI*IA-1:0] ibase, imask;
  logic [NI*WW-1:0] iwait;
  logic memcs_oe, memcs, iocs_oe, iocs, rdy_oe, rdy;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  isa16_slave_resp i_isa16_slave_resp (
    .clk_i(clk), .rst_ni(rst_ni), .la_i(la), .sa_i(sa),
    .memr_ni(memr_n), .memw_ni(memw_n), .ior_ni(ior_n), .iow_ni(iow_n),
    .mem_base_i(mbase), .mem_mask_i(mmask), .mem_wait_i(mwait),
    .io_base_i(ibase), .io_mask_i(imask), .io_wait_i(iwait),
    .memcs_oe_o(memcs_oe), .memcs_o(memcs), .iocs_oe_o(iocs_oe), .iocs_o(iocs),
    .rdy_oe_o(rdy_oe), .rdy_o(rdy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit mem_hit_f(input logic [MA-1:0] a);
    for (int i = 0; i < NM; i++)
      if ((a & mmask[i*MA +: MA]) == (mbase[i*MA +: MA] & mmask[i*MA +: MA])) return 1;
    return 0;
  endfunction

  function automatic int mem_wait_f(input logic [MA-1:0] a);
    for (int i = 0; i < NM; i++)
      if ((a & mmask[i*MA +: MA]) == (mbase[i*MA +: MA] & mmask[i*MA +: MA]))
        return int'(mwait[i*WW +: WW]);
    return 0;
  endfunction

  function automatic bit io_hit_f(input logic [15:0] a);
    for (int i = 0; i < NI; i++)
      if ((a[15:1] & imask[i*IA +: IA]) == (ibase[i*IA +: IA] & imask[i*IA +: IA])) return 1;
    return 0;
  endfunction

  function automatic int io_wait_f(input logic [15:0] a);
    for (int i = 0; i < NI; i++)
      if ((a[15:1] & imask[i*IA +: IA]) == (ibase[i*IA +: IA] & imask[i*IA +: IA]))
        return int'(iwait[i*WW +: WW]);
    return 0;
  endfunction

  task automatic strobe(input int kind, input logic v);
    case (kind)
      0: memr_n = v;
      1: memw_n = v;
      2: ior_n  = v;
      default: iow_n = v;
    endcase
  endtask

  // one bus cycle from a negedge; expects W held clocks then release
  task automatic run_cycle(input int kind, input string req);
    int exp_w, cnt;
    bit hit;
    hit   = (kind < 2) ? mem_hit_f(la) : io_hit_f(sa);
    exp_w = !hit ? 0 : ((kind < 2) ? mem_wait_f(la) : io_wait_f(sa));
    #1;
    chk("R1 mem select", int'(memcs_oe), int'(mem_hit_f(la)));
    chk("R2 io select", int'(iocs_oe), int'(io_hit_f(sa)));
    strobe(kind, 1'b0);
    cnt = 0;
    for (int k = 0; k < exp_w + 3; k++) begin
      @(posedge clk); @(negedge clk);
      if (rdy_oe) cnt++;
    end
    chk({req, " ready stretch"}, cnt, exp_w);
    chk("R5 released at end", int'(rdy_oe), 0);
    chk("R3 data lows", int'({memcs, iocs, rdy}), 0);
    strobe(kind, 1'b1);
    #1 chk("R6 idle ready", int'(rdy_oe), 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    la = '0; sa = '0;
    mbase = {7'h05, 7'h04}; mmask = {7'h7F, 7'h7E};
    mwait = {4'd9, 4'd3};
    ibase = {15'h0150, 15'h0150}; imask = {15'h7FFF, 15'h7FF8};
    iwait = {4'd7, 4'd0};
    repeat (3) @(negedge clk);
    chk("R8 ready in reset", int'(rdy_oe), 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R8 ready after reset", int'(rdy_oe), 0);
    chk("R3 data lows reset", int'({memcs, iocs, rdy}), 0);

    // R9: la=5 hits both windows, window 0 (wait 3) wins
    la = 7'h05; run_cycle(0, "R9 priority");
    chk("R9 mem wait", mem_wait_f(la), 3);
    la = 7'h05; run_cycle(1, "R4 mem write");
    // window1 only hit: mask 0x7E of win0 excludes 0x05? no: 0x05&0x7E=4 hits win0
    la = 7'h06; run_cycle(0, "R7 mem miss");
    // R2: bit0 of sa ignored; win0 wait 0 wins over win1 wait 7
    sa = 16'h02A0; run_cycle(2, "R5 zero wait");
    sa = 16'h02A1; #1 chk("R2 sa0 ignored", int'(iocs_oe), 1);
    run_cycle(3, "R9 io priority");
    // single io window, wait 7
    imask = {15'h7FFF, 15'h7FFF}; ibase = {15'h0150, 15'h0001};
    sa = 16'h02A0; run_cycle(2, "R4 io wait");
    sa = 16'h0300; run_cycle(3, "R7 io miss");
    // io strobe on memory-only address: no stretch
    la = 7'h05; sa = 16'h0300; run_cycle(2, "R7 wrong space");
    // maximum wait
    mwait = {4'd0, 4'd15}; la = 7'h04; run_cycle(0, "R5 max wait");
    // mask zero matches everything
    mmask = '0; la = 7'h33; run_cycle(1, "R1 mask zero");

    // R6: early release then restart
    mmask = {7'h7F, 7'h7F}; mbase = {7'h10, 7'h11}; mwait = {4'd2, 4'd10};
    la = 7'h11;
    memr_n = 0;
    for (int k = 0; k < 3; k++) begin @(posedge clk); @(negedge clk); end
    chk("R6 stretch active", int'(rdy_oe), 1);
    memr_n = 1;
    #1 chk("R6 abort release", int'(rdy_oe), 0);
    @(negedge clk);
    run_cycle(0, "R6 restart full");

    // random mix
    for (int t = 0; t < 60; t++) begin
      mbase = NM*MA'($urandom); mmask = NM*MA'($urandom) | 14'h3F3F;
      mwait = NM*WW'($urandom);
      ibase = NI*IA'($urandom); imask = NI*IA'($urandom) | 30'h3FF83FF8;
      iwait = NI*WW'($urandom);
      if ($urandom % 2) la = mbase[MA-1:0]; else la = MA'($urandom);
      if ($urandom % 2) sa = {ibase[IA-1:0], 1'($urandom)}; else sa = 16'($urandom);
      run_cycle(int'($urandom % 4), "R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule